// File: doc/BRIEF.md
# Synthesizer Init and Frequency Sweep Sequencer

This block drives a serial register-write engine on behalf of a fractional-N frequency synthesizer. When the user presents a new configuration, it captures a start frequency, an end frequency, a step size and a dwell length. It then replays a fixed power-up list of register writes. After that it sweeps the output frequency in steps until the user loads a new configuration.

A frequency is an integer divider word plus a 24-bit fractional divider word. Each sweep point is applied with exactly two writes: the integer part to register 03h, then the fractional part to register 04h. The step is added to the fractional word, and any carry goes into the integer word. A point past the end frequency sends the sweep back to the start. A programmable dwell separates the sweep points.

Each write is offered to the engine as a one-cycle request, with address and data held steady until the engine answers with a one-cycle done pulse.

Top module: `pll_sweep_seq`

## Requirements
- R1: After reset, `wr_req` stays low and no write is issued until `cfg_load` is pulsed.
- R2: On `cfg_load`, the start, end, step and dwell inputs are captured. Later changes to those inputs without a new `cfg_load` have no effect on any write.
- R3: After `cfg_load`, fifteen writes are issued in this order (address: data):
  - 00h: 0x000000
  - 00h: 0x0A7975
  - 06h: 0x000002
  - 09h: 0x547FFF
  - 0Ah: 0x002046
  - 0Bh: 0x07C021
  - 10h: 0x0000B2
  - 11h: 0x080002
  - 12h: 0x000003
  - 05h: 0x000188
  - 05h: 0x00A090
  - 05h: 0x002898
  - 05h: 0x002018
  - 05h: 0x001628
  - 05h: 0x0060A0
- R4: `wr_req` is high for exactly one cycle per write. `wr_addr` and `wr_data` hold until `wr_done` is seen. Outside the dwell, the next request rises in the cycle right after the one in which `wr_done` was high.
- R5: Each sweep point is written as 03h carrying the integer word zero-extended to 24 bits, then 04h carrying the 24-bit fractional word. The first point written is the start frequency.
- R6: After the done of a 04h write, the next 03h request rises max(D,1)+1 cycles after the cycle in which that done was high, where D is the captured dwell.
- R7: Each new point equals the previous point plus the step, with the step added to the fractional word and its carry propagated into the integer word.
- R8: A point equal to the end frequency is still used. A point that would exceed the end frequency is replaced by the start frequency.
- R9: A `cfg_load` during the sweep restarts the full fifteen-write list and then sweeps using the newly captured values.
- R10: A `wr_done` pulse while no write is pending has no effect on sequencing or dwell timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture configuration and restart initialization |
| cfg_start_int | input | INT_W | Start frequency, integer word |
| cfg_start_frac | input | 24 | Start frequency, fractional word |
| cfg_end_int | input | INT_W | End frequency, integer word |
| cfg_end_frac | input | 24 | End frequency, fractional word |
| cfg_step_frac | input | 24 | Step size in fractional units |
| cfg_dwell | input | DWELL_W | Dwell length in cycles between sweep points |
| wr_req | output | 1 | One-cycle write request to the engine |
| wr_addr | output | 5 | Register address of the pending write |
| wr_data | output | 24 | Register data of the pending write |
| wr_done | input | 1 | One-cycle completion pulse from the engine |

## Verification
The assertions assume the following about the inputs:
- The start frequency is not above the end frequency; the band check is gated on this.
- `cfg_load` arrives only while no write is pending, so a stale done from an earlier write cannot be taken as the answer to a new request.
- The engine answers each request with a single done pulse.

The bench's engine model answers every request after a fixed two-cycle latency. The bench pulses `cfg_load` only in the cycle right after a 04h write completes, which falls inside the dwell. Its configurations all keep start at or below end, including one that lands exactly on the end value.

// File: rtl/pll_sweep_pkg.sv
package pll_sweep_pkg;

  localparam int REG_AW = 5;
  localparam int REG_DW = 24;
  localparam int INIT_LEN = 15;

  localparam logic [REG_AW-1:0] REG_INT  = 5'h03;
  localparam logic [REG_AW-1:0] REG_FRAC = 5'h04;

  // write-list index: 0..14 init, 15 integer write, 16 fractional write
  localparam logic [4:0] IDX_INT  = 5'd15;
  localparam logic [4:0] IDX_FRAC = 5'd16;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DWELL} seq_state_t;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [REG_DW-1:0] data;
  } wr_entry_t;

  // power-up write list, order matters
  function automatic wr_entry_t init_entry(input logic [4:0] i);
    wr_entry_t e;
    case (i)
      5'd0:  e = '{5'h00, 24'h000000};
      5'd1:  e = '{5'h00, 24'h0A7975};
      5'd2:  e = '{5'h06, 24'h000002};
      5'd3:  e = '{5'h09, 24'h547FFF};
      5'd4:  e = '{5'h0A, 24'h002046};
      5'd5:  e = '{5'h0B, 24'h07C021};
      5'd6:  e = '{5'h10, 24'h0000B2};
      5'd7:  e = '{5'h11, 24'h080002};
      5'd8:  e = '{5'h12, 24'h000003};
      5'd9:  e = '{5'h05, 24'h000188};
      5'd10: e = '{5'h05, 24'h00A090};
      5'd11: e = '{5'h05, 24'h002898};
      5'd12: e = '{5'h05, 24'h002018};
      5'd13: e = '{5'h05, 24'h001628};
      5'd14: e = '{5'h05, 24'h0060A0};
      default: e = '{5'h00, 24'h000000};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/sweep_freq_acc.sv
module sweep_freq_acc #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  start_int,
  input  logic [FRAC_W-1:0] start_frac,
  input  logic [INT_W-1:0]  end_int,
  input  logic [FRAC_W-1:0] end_frac,
  input  logic [FRAC_W-1:0] step_frac,
  input  logic              advance,
  output logic [INT_W-1:0]  cur_int,
  output logic [FRAC_W-1:0] cur_frac
);
  localparam int FW = INT_W + FRAC_W;

  logic [FW-1:0]     lo_q, hi_q, cur_q;
  logic [FRAC_W-1:0] step_q;
  logic              valid_q;

  // step enters the fractional field; carry ripples into the integer field
  function automatic logic [FW-1:0] next_freq(input logic [FW-1:0] cur,
                                              input logic [FRAC_W-1:0] step,
                                              input logic [FW-1:0] lo,
                                              input logic [FW-1:0] hi);
    logic [FW:0] s;
    s = {1'b0, cur} + {{(INT_W+1){1'b0}}, step};
    if (s > {1'b0, hi}) return lo;
    return s[FW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= '0;
      cur_q   <= '0;
      step_q  <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      lo_q    <= {start_int, start_frac};
      hi_q    <= {end_int, end_frac};
      cur_q   <= {start_int, start_frac};
      step_q  <= step_frac;
      valid_q <= 1'b1;
    end else if (advance) begin
      cur_q <= next_freq(cur_q, step_q, lo_q, hi_q);
    end
  end

  assign cur_int  = cur_q[FW-1:FRAC_W];
  assign cur_frac = cur_q[FRAC_W-1:0];

  // R8: the swept point never leaves the captured band
  a_r8_freq_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && lo_q <= hi_q) |-> (cur_q >= lo_q && cur_q <= hi_q));

endmodule

// File: rtl/sweep_dwell_timer.sv
module sweep_dwell_timer #(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [DWELL_W-1:0] cfg_len,
  input  logic               start,
  output logic               expire
);
  logic [DWELL_W-1:0] len_q, cnt_q, eff_len;
  logic               busy_q;

  assign eff_len = (len_q == '0) ? DWELL_W'(1) : len_q;
  assign expire  = busy_q && (cnt_q == DWELL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cfg_load) begin
      len_q  <= cfg_len;
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= eff_len;
    end else if (busy_q) begin
      if (expire) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q - DWELL_W'(1);
    end
  end

  // R6: a started dwell cannot finish in the cycle right after it starts unless it is one cycle long
  a_r6_no_short_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cfg_load && eff_len > DWELL_W'(1)) |=> !expire);

endmodule

// File: rtl/pll_sweep_seq.sv
module pll_sweep_seq
  import pll_sweep_pkg::*;
#(
  parameter int INT_W   = 8,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [INT_W-1:0]   cfg_start_int,
  input  logic [23:0]        cfg_start_frac,
  input  logic [INT_W-1:0]   cfg_end_int,
  input  logic [23:0]        cfg_end_frac,
  input  logic [23:0]        cfg_step_frac,
  input  logic [DWELL_W-1:0] cfg_dwell,
  output logic               wr_req,
  output logic [4:0]         wr_addr,
  output logic [23:0]        wr_data,
  input  logic               wr_done
);
  localparam int FRAC_W = REG_DW;
  localparam int PAD_W  = REG_DW - INT_W;

  seq_state_t        state_q;
  logic [4:0]        idx_q;
  logic [INT_W-1:0]  cur_int;
  logic [FRAC_W-1:0] cur_frac;
  wr_entry_t         init_e;

  // named internal events
  logic write_ack, pair_done, dwell_exp;
  assign write_ack = (state_q == S_WAIT) && wr_done;
  assign pair_done = write_ack && (idx_q == IDX_FRAC);

  sweep_freq_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .start_int(cfg_start_int), .start_frac(cfg_start_frac),
    .end_int(cfg_end_int), .end_frac(cfg_end_frac),
    .step_frac(cfg_step_frac), .advance(dwell_exp),
    .cur_int(cur_int), .cur_frac(cur_frac)
  );

  sweep_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_len(cfg_dwell),
    .start(pair_done), .expire(dwell_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else if (cfg_load) begin
      state_q <= S_ISSUE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (wr_done) begin
          if (idx_q == IDX_FRAC) state_q <= S_DWELL;
          else begin
            idx_q   <= idx_q + 5'd1;
            state_q <= S_ISSUE;
          end
        end
        S_DWELL: if (dwell_exp) begin
          idx_q   <= IDX_INT;
          state_q <= S_ISSUE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign init_e = init_entry(idx_q);
  assign wr_req = (state_q == S_ISSUE);

  always_comb begin
    if (idx_q == IDX_INT) begin
      wr_addr = REG_INT;
      wr_data = {{PAD_W{1'b0}}, cur_int};
    end else if (idx_q == IDX_FRAC) begin
      wr_addr = REG_FRAC;
      wr_data = cur_frac;
    end else begin
      wr_addr = init_e.addr;
      wr_data = init_e.data;
    end
  end

  // R4: request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R4: address and data held while the engine works
  a_r4_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && !wr_done && !cfg_load) |=> ($stable(wr_addr) && $stable(wr_data)));

  // R5: the fractional write follows the integer write at once
  a_r5_frac_after_int: assert property (@(posedge clk) disable iff (!rst_n)
    (write_ack && idx_q == IDX_INT && !cfg_load) |=> (wr_req && wr_addr == REG_FRAC));

  // R6: end of dwell issues the integer write
  a_r6_resume_after_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (dwell_exp && !cfg_load) |=> (wr_req && wr_addr == REG_INT));

  // R1: nothing is requested before the first configuration
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !cfg_load) |=> !wr_req);

endmodule

// File: tb/pll_sweep_seq_tb.sv
module pll_sweep_seq_tb;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_start_int = '0, cfg_end_int = '0;
  logic [23:0] cfg_start_frac = '0, cfg_end_frac = '0, cfg_step_frac = '0;
  logic [15:0] cfg_dwell = '0;
  logic        wr_req;
  logic [4:0]  wr_addr;
  logic [23:0] wr_data;
  logic        wr_done = 1'b0;

  pll_sweep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_start_int(cfg_start_int), .cfg_start_frac(cfg_start_frac),
    .cfg_end_int(cfg_end_int), .cfg_end_frac(cfg_end_frac),
    .cfg_step_frac(cfg_step_frac), .cfg_dwell(cfg_dwell),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, n_log = 0;
  bit stray_en = 1'b0;
  int req_cyc [0:127];
  int done_cyc[0:127];
  logic [4:0]  addr_log[0:127];
  logic [23:0] data_log[0:127];

  initial forever begin @(posedge clk); cyc++; end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [28:0] exp_init(input int i);
    case (i)
      0: return {5'h00, 24'h000000};  1: return {5'h00, 24'h0A7975};
      2: return {5'h06, 24'h000002};  3: return {5'h09, 24'h547FFF};
      4: return {5'h0A, 24'h002046};  5: return {5'h0B, 24'h07C021};
      6: return {5'h10, 24'h0000B2};  7: return {5'h11, 24'h080002};
      8: return {5'h12, 24'h000003};  9: return {5'h05, 24'h000188};
      10: return {5'h05, 24'h00A090}; 11: return {5'h05, 24'h002898};
      12: return {5'h05, 24'h002018}; 13: return {5'h05, 24'h001628};
      default: return {5'h05, 24'h0060A0};
    endcase
  endfunction

  // engine model: done after LAT cycles, optional stray done after a 04h write
  initial forever begin
    if (wr_req === 1'b1) begin
      logic [4:0] a; logic [23:0] d; int k;
      a = wr_addr; d = wr_data; k = n_log;
      req_cyc[k] = cyc; addr_log[k] = a; data_log[k] = d; n_log++;
      @(negedge clk);
      check(wr_req == 1'b0, "R4 request pulse width", 32'(wr_req), 0);
      repeat (LAT-1) @(negedge clk);
      check(wr_addr == a && wr_data == d, "R4 hold until done", {3'b0, wr_addr, wr_data}, {3'b0, a, d});
      wr_done = 1'b1; done_cyc[k] = cyc;
      @(negedge clk);
      wr_done = 1'b0;
      if (stray_en && a == 5'h04) begin
        @(negedge clk); wr_done = 1'b1;
        @(negedge clk); wr_done = 1'b0;
      end
    end else @(negedge clk);
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  function automatic logic [31:0] nf(input logic [31:0] f, input logic [23:0] s,
                                     input logic [31:0] lo, input logic [31:0] hi);
    logic [32:0] t;
    t = {1'b0, f} + 33'(s);
    return (t > {1'b0, hi}) ? lo : t[31:0];
  endfunction

  task automatic load_cfg(input logic [31:0] lo, input logic [31:0] hi,
                          input logic [23:0] st, input logic [15:0] dw);
    cfg_start_int = lo[31:24]; cfg_start_frac = lo[23:0];
    cfg_end_int = hi[31:24]; cfg_end_frac = hi[23:0];
    cfg_step_frac = st; cfg_dwell = dw; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    // R2: scramble the inputs; captured values must rule
    cfg_start_int = 8'h11; cfg_start_frac = 24'h123456;
    cfg_end_int = 8'hEE; cfg_end_frac = 24'hABCDEF;
    cfg_step_frac = 24'h000001; cfg_dwell = 16'd40;
  endtask

  // checks 15 init writes + 4 sweep pairs starting at log index base
  task automatic check_run(input int base, input logic [31:0] lo, input logic [31:0] hi,
                           input logic [23:0] st, input int dw, input string tag);
    logic [31:0] f;
    int deff;
    wait (n_log >= base + 24);
    deff = (dw < 1) ? 1 : dw;
    for (int i = 0; i < 15; i++) begin
      check({addr_log[base+i], data_log[base+i]} == exp_init(i), {"R3 init entry ", tag},
            {3'b0, addr_log[base+i], data_log[base+i]}, {3'b0, exp_init(i)});
    end
    for (int i = 0; i < 16; i++) begin
      check(req_cyc[base+i+1] - done_cyc[base+i] == 1, {"R4 back-to-back gap ", tag},
            req_cyc[base+i+1] - done_cyc[base+i], 1);
    end
    f = lo;
    for (int k = 0; k < 4; k++) begin
      int j;
      j = base + 15 + 2*k;
      check(addr_log[j] == 5'h03 && data_log[j] == {16'h0, f[31:24]}, {"R5 R7 R8 integer write ", tag},
            {3'b0, addr_log[j], data_log[j]}, {8'h03, 16'h0, f[31:24]});
      check(addr_log[j+1] == 5'h04 && data_log[j+1] == f[23:0], {"R5 R7 R8 fraction write ", tag},
            {3'b0, addr_log[j+1], data_log[j+1]}, {8'h04, f[23:0]});
      if (k < 3 || n_log > j + 2) begin
        check(req_cyc[j+2] - done_cyc[j+1] == deff + 1, {"R6 R10 dwell gap ", tag},
              req_cyc[j+2] - done_cyc[j+1], deff + 1);
      end
      f = nf(f, st, lo, hi);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(wr_req == 1'b0, "R1 reset request low", 32'(wr_req), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(n_log == 0, "R1 no write before config", n_log, 0);
    check(wr_req == 1'b0, "R1 request low while idle", 32'(wr_req), 0);
  endtask

  task automatic t_sweep_carry_wrap();
    int base;
    stray_en = 1'b1;
    base = n_log;
    load_cfg({8'd80, 24'hFFFF00}, {8'd81, 24'h000200}, 24'h000180, 16'd5);
    check_run(base, {8'd80, 24'hFFFF00}, {8'd81, 24'h000200}, 24'h000180, 5, "sweep1");
  endtask

  task automatic t_restart();
    int m, base;
    stray_en = 1'b0;
    m = n_log;
    wait (n_log > m && addr_log[n_log-1] == 5'h04);
    @(posedge wr_done);
    @(negedge clk);
    base = n_log;
    load_cfg({8'd100, 24'h000000}, {8'd101, 24'h000000}, 24'h800000, 16'd0);
    // R9: full list replayed with the new band
    check_run(base, {8'd100, 24'h000000}, {8'd101, 24'h000000}, 24'h800000, 0, "R9 restart");
  endtask

  initial begin
    t_reset();
    t_sweep_carry_wrap();
    t_restart();
    report();
  end

endmodule